// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block sits beside the write port of a configuration memory for a programmable-logic fabric built from columns. The fabric holds an upper and a lower half, each half holds a number of rows, each row holds a number of columns, and each column holds some number of frames. A frame is 41 words of 32 bits. The host places a starting frame address on the load port. It then offers configuration words through a valid/ready handshake. The block counts the words accepted within the current frame. When a frame is complete it moves the address on to the next frame, carrying from the frame field into the column field, then the row field, then the half bit.

A small writable table gives each column its block-type code and its frame count. The host programs the table before it streams any words. When the sequencer enters a column, the block-type field of the address is taken from that column's table entry. The column's frame count decides when the frame field wraps. The address the block presents applies to every word accepted while that address is shown. After the final frame of the whole fabric the block raises an end flag and refuses further words until the host loads a new address.

Top module: `frame_addr_seq`

## Requirements
- R1: A word is accepted in a cycle where `wordValid` and `wordReady` are both high. In the cycle after the 41st accepted word of a frame, `frameDone` is high for exactly one cycle and `curAddr` shows the next frame's address. After 40 words, `frameDone` stays low and the address does not change.
- R2: The fields of `curAddr` are: bits 6:0 frame within the column, bits 14:7 column, bits 19:15 row within the half, bit 20 half (0 for the upper half, 1 for the lower half), bits 23:21 block type.
- R3: Bits 31:24 of `curAddr` always read zero, even after a load whose upper byte is nonzero.
- R4: After reset, every table entry holds 36 frames with block type 0. The frame field counts up by one per frame. After the last frame of the column (frame count minus one) it returns to 0 and the column field increments.
- R5: A write with `tblWrEn` high stores `tblWrType` and `tblWrFrames` for column `tblWrCol`. When the column field advances, the block-type field takes the new column's table type. The column's own frame count sets where the frame field wraps.
- R6: When the frame field wraps in the last column (NUM_COLS-1), the column field returns to 0, the type field takes column 0's type, and the row field increments.
- R7: When the row field wraps after the last row of a half (ROWS_PER_HALF-1), the row returns to 0 and the half bit is set to 1.
- R8: Completing the last frame of the last column of the last row of the lower half raises `endOfFabric`. It also pulses `frameDone`, keeps `curAddr` unchanged, and drops `wordReady`. Further valid words are not accepted and change nothing.
- R9: While `loadEn` is high, `wordReady` is low. On that edge `curAddr` takes `loadAddr` (upper byte cleared), the word count restarts at zero, and `endOfFabric` clears.
- R10: `curAddr` stays constant in every cycle that has neither an accepted word nor a load.
- R11: Synchronous active-high `rst` clears the address, the word count and `endOfFabric`, and restores the table defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Load strobe for the starting address |
| loadAddr | input | 32 | Address taken on a load |
| tblWrEn | input | 1 | Column table write strobe |
| tblWrCol | input | COL_W | Column written |
| tblWrType | input | 3 | Block-type code for that column |
| tblWrFrames | input | 7 | Frame count for that column |
| wordValid | input | 1 | Host offers a configuration word |
| wordReady | output | 1 | Block can take a word |
| curAddr | output | 32 | Frame address of words accepted now |
| frameDone | output | 1 | One-cycle pulse after a frame completes |
| endOfFabric | output | 1 | Last frame of the fabric has been written |

## Verification
A load and a frame boundary can fall in the same cycle. The bench holds `wordValid` high with 40 words of a frame already accepted, and raises `loadEn` in that same cycle. The expected result is that `wordReady` is low during the load, no `frameDone` follows, and the loaded address appears. A further 41 words, not 1, are then needed before the next boundary. The end of the fabric and a frame boundary also coincide by design: the bench checks that the final frame pulses `frameDone` while the address holds and `endOfFabric` rises.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

  localparam int MINOR_LSB = 0;
  localparam int MAJOR_LSB = 7;
  localparam int ROW_LSB   = 15;
  localparam int HALF_BIT  = 20;
  localparam int TYPE_LSB  = 21;
endpackage

// File: rtl/cfa_ctrl.sv
module cfa_ctrl
  import cfa_pkg::*;
#(
  parameter int WORDS_PER_FRAME = 41
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       loadEn,
  input  logic       wordValid,
  input  logic       fabricLast,
  output logic       wordReady,
  output logic       frameDone,
  output logic       endOfFabric,
  output seqStrobe_t strb
);
  localparam int CNT_W = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS_PER_FRAME - 1);

  logic [CNT_W-1:0] wordCnt;
  logic accept;
  logic frameEnd;

  assign wordReady = !endOfFabric && !loadEn;
  assign accept    = wordValid && wordReady;
  assign frameEnd  = accept && (wordCnt == LAST_WORD);

  always_comb begin
    strb.load = loadEn;
    strb.step = frameEnd && !fabricLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordCnt     <= '0;
      endOfFabric <= 1'b0;
      frameDone   <= 1'b0;
    end else begin
      frameDone <= frameEnd;
      if (loadEn) begin
        wordCnt     <= '0;
        endOfFabric <= 1'b0;
      end else if (accept) begin
        if (frameEnd) begin
          wordCnt <= '0;
          if (fabricLast) endOfFabric <= 1'b1;
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfa_datapath.sv
module cfa_datapath
  import cfa_pkg::*;
#(
  parameter int NUM_COLS       = 4,
  parameter int ROWS_PER_HALF  = 2,
  parameter int DEFAULT_FRAMES = 36,
  parameter int COL_W          = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strb,
  input  logic [31:0]      loadAddr,
  input  logic             tblWrEn,
  input  logic [COL_W-1:0] tblWrCol,
  input  logic [2:0]       tblWrType,
  input  logic [6:0]       tblWrFrames,
  output logic [31:0]      curAddr,
  output logic             fabricLast
);
  logic       half;
  logic [4:0] row;
  logic [2:0] btype;
  logic [7:0] major;
  logic [6:0] minor;

  logic [2:0] colType   [NUM_COLS];
  logic [6:0] colFrames [NUM_COLS];

  logic [COL_W-1:0] curCol;
  logic [COL_W-1:0] nextCol;
  logic minLast, majLast, rowLast;

  assign curCol  = major[COL_W-1:0];
  assign nextCol = curCol + 1'b1;
  assign minLast = ({1'b0, minor} + 8'd1) >= {1'b0, colFrames[curCol]};
  assign majLast = major >= 8'(NUM_COLS - 1);
  assign rowLast = row >= 5'(ROWS_PER_HALF - 1);
  assign fabricLast = half && rowLast && majLast && minLast;

  assign curAddr = {8'h00, btype, half, row, major, minor};

  // column table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_COLS; c++) begin
        colType[c]   <= 3'd0;
        colFrames[c] <= 7'(DEFAULT_FRAMES);
      end
    end else if (tblWrEn) begin
      colType[tblWrCol]   <= tblWrType;
      colFrames[tblWrCol] <= tblWrFrames;
    end
  end

  // address register with hierarchical carry
  always_ff @(posedge clk) begin
    if (rst) begin
      half  <= 1'b0;
      row   <= '0;
      btype <= '0;
      major <= '0;
      minor <= '0;
    end else if (strb.load) begin
      btype <= loadAddr[TYPE_LSB +: 3];
      half  <= loadAddr[HALF_BIT];
      row   <= loadAddr[ROW_LSB +: 5];
      major <= loadAddr[MAJOR_LSB +: 8];
      minor <= loadAddr[MINOR_LSB +: 7];
    end else if (strb.step) begin
      if (!minLast) begin
        minor <= minor + 1'b1;
      end else begin
        minor <= '0;
        if (!majLast) begin
          major <= major + 1'b1;
          btype <= colType[nextCol];
        end else begin
          major <= '0;
          btype <= colType[0];
          if (!rowLast) begin
            row <= row + 1'b1;
          end else begin
            row  <= '0;
            half <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq
  import cfa_pkg::*;
#(
  parameter int WORDS_PER_FRAME = 41,
  parameter int NUM_COLS        = 4,
  parameter int ROWS_PER_HALF   = 2,
  parameter int DEFAULT_FRAMES  = 36,
  localparam int COL_W          = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic [31:0]      loadAddr,
  input  logic             tblWrEn,
  input  logic [COL_W-1:0] tblWrCol,
  input  logic [2:0]       tblWrType,
  input  logic [6:0]       tblWrFrames,
  input  logic             wordValid,
  output logic             wordReady,
  output logic [31:0]      curAddr,
  output logic             frameDone,
  output logic             endOfFabric
);
  seqStrobe_t strb;
  logic fabricLast;

  cfa_ctrl #(.WORDS_PER_FRAME(WORDS_PER_FRAME)) i_ctrl (
    .clk(clk), .rst(rst), .loadEn(loadEn), .wordValid(wordValid),
    .fabricLast(fabricLast), .wordReady(wordReady), .frameDone(frameDone),
    .endOfFabric(endOfFabric), .strb(strb)
  );

  cfa_datapath #(
    .NUM_COLS(NUM_COLS), .ROWS_PER_HALF(ROWS_PER_HALF),
    .DEFAULT_FRAMES(DEFAULT_FRAMES), .COL_W(COL_W)
  ) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .loadAddr(loadAddr),
    .tblWrEn(tblWrEn), .tblWrCol(tblWrCol), .tblWrType(tblWrType),
    .tblWrFrames(tblWrFrames), .curAddr(curAddr), .fabricLast(fabricLast)
  );
endmodule

// File: rtl/frame_addr_seq_chk.sv
module frame_addr_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        loadEn,
  input logic        wordValid,
  input logic        wordReady,
  input logic [31:0] curAddr,
  input logic        frameDone,
  input logic        endOfFabric
);
  a_r1_done_follows_accept: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> $past(wordValid && wordReady));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    curAddr[31:24] == 8'h00);

  a_r8_no_ready_at_end: assert property (@(posedge clk) disable iff (rst)
    endOfFabric |-> !wordReady);

  a_r8_end_sticky: assert property (@(posedge clk) disable iff (rst)
    (endOfFabric && !loadEn) |=> endOfFabric);

  a_r9_load_clears_end: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> !endOfFabric);

  a_r9_no_ready_on_load: assert property (@(posedge clk) disable iff (rst)
    loadEn |-> !wordReady);

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !(wordValid && wordReady)) |=> $stable(curAddr));
endmodule

bind frame_addr_seq frame_addr_seq_chk i_chk (
  .clk(clk), .rst(rst), .loadEn(loadEn), .wordValid(wordValid),
  .wordReady(wordReady), .curAddr(curAddr), .frameDone(frameDone),
  .endOfFabric(endOfFabric)
);

// File: tb/test_frame_addr_seq.sv
`timescale 1ns/1ps
module test_frame_addr_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        loadEn = 1'b0;
  logic [31:0] loadAddr = '0;
  logic        tblWrEn = 1'b0;
  logic [1:0]  tblWrCol = '0;
  logic [2:0]  tblWrType = '0;
  logic [6:0]  tblWrFrames = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [31:0] curAddr;
  logic        frameDone;
  logic        endOfFabric;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  frame_addr_seq i_frame_addr_seq (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .tblWrEn(tblWrEn), .tblWrCol(tblWrCol), .tblWrType(tblWrType),
    .tblWrFrames(tblWrFrames), .wordValid(wordValid), .wordReady(wordReady),
    .curAddr(curAddr), .frameDone(frameDone), .endOfFabric(endOfFabric)
  );

  function automatic logic [31:0] mk(input logic h, input logic [4:0] r,
      input logic [2:0] t, input logic [7:0] maj, input logic [6:0] mnr);
    return {8'h00, t, h, r, maj, mnr};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wordValid = 1'b1;
    end
    @(negedge clk) wordValid = 1'b0;
  endtask

  task automatic loadStart(input logic [31:0] a);
    @(negedge clk) begin loadEn = 1'b1; loadAddr = a; end
    @(negedge clk) loadEn = 1'b0;
  endtask

  task automatic writeCol(input logic [1:0] c, input logic [2:0] t, input logic [6:0] f);
    @(negedge clk) begin tblWrEn = 1'b1; tblWrCol = c; tblWrType = t; tblWrFrames = f; end
    @(negedge clk) tblWrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic tResetState();
    check("R11 addr", curAddr, 32'h0);
    check("R11 end", {31'b0, endOfFabric}, 32'd0);
    check("R11 done", {31'b0, frameDone}, 32'd0);
    check("R11 ready", {31'b0, wordReady}, 32'd1);
  endtask

  task automatic tBoundary();
    pushWords(40);
    check("R1 no pulse at 40", {31'b0, frameDone}, 32'd0);
    check("R1 addr held at 40", curAddr, 32'h0);
    pushWords(1);
    check("R1 pulse at 41", {31'b0, frameDone}, 32'd1);
    check("R2 next minor", curAddr, mk(0, 0, 0, 0, 1));
    @(negedge clk);
    check("R1 pulse one cycle", {31'b0, frameDone}, 32'd0);
    repeat (5) @(negedge clk);
    check("R10 idle stable", curAddr, mk(0, 0, 0, 0, 1));
  endtask

  task automatic tMinorWrap();
    loadStart(mk(0, 0, 0, 0, 35));
    pushWords(41);
    check("R4 minor wrap to next column", curAddr, mk(0, 0, 0, 1, 0));
  endtask

  task automatic tTable();
    writeCol(2'd2, 3'd1, 7'd3);
    writeCol(2'd3, 3'd2, 7'd2);
    loadStart(mk(0, 0, 0, 1, 35));
    pushWords(41);
    check("R5 type from table", curAddr, mk(0, 0, 1, 2, 0));
    pushWords(41 * 3);
    check("R5 short column count", curAddr, mk(0, 0, 2, 3, 0));
  endtask

  task automatic tRowHalf();
    loadStart(mk(0, 0, 2, 3, 1));
    pushWords(41);
    check("R6 row step", curAddr, mk(0, 1, 0, 0, 0));
    loadStart(mk(0, 1, 2, 3, 1));
    pushWords(41);
    check("R7 half step", curAddr, mk(1, 0, 0, 0, 0));
  endtask

  task automatic tEnd();
    loadStart(mk(1, 1, 2, 3, 1));
    pushWords(41);
    check("R8 end flag", {31'b0, endOfFabric}, 32'd1);
    check("R8 final pulse", {31'b0, frameDone}, 32'd1);
    check("R8 addr held", curAddr, mk(1, 1, 2, 3, 1));
    check("R8 ready low", {31'b0, wordReady}, 32'd0);
    pushWords(50);
    check("R8 words ignored addr", curAddr, mk(1, 1, 2, 3, 1));
    check("R8 words ignored end", {31'b0, endOfFabric}, 32'd1);
    check("R8 no extra pulse", {31'b0, frameDone}, 32'd0);
  endtask

  task automatic tLoad();
    loadStart(32'hAB00_0000 | mk(0, 0, 0, 1, 4));
    check("R3 upper byte zero", curAddr, mk(0, 0, 0, 1, 4));
    check("R9 end cleared", {31'b0, endOfFabric}, 32'd0);
    pushWords(40);
    @(negedge clk) begin wordValid = 1'b1; loadEn = 1'b1; loadAddr = mk(0, 0, 0, 0, 0); end
    #1 check("R9 ready low in load", {31'b0, wordReady}, 32'd0);
    @(negedge clk) begin loadEn = 1'b0; wordValid = 1'b0; end
    check("R9 load wins at boundary", curAddr, mk(0, 0, 0, 0, 0));
    check("R9 no pulse on load", {31'b0, frameDone}, 32'd0);
    pushWords(40);
    check("R9 count restarted", curAddr, mk(0, 0, 0, 0, 0));
    pushWords(1);
    check("R9 boundary after 41", curAddr, mk(0, 0, 0, 0, 1));
  endtask

  task automatic tResetMid();
    pushWords(10);
    doReset();
    check("R11 reset addr", curAddr, 32'h0);
    pushWords(40);
    check("R11 count cleared", {31'b0, frameDone}, 32'd0);
    pushWords(1);
    check("R11 boundary after reset", curAddr, mk(0, 0, 0, 0, 1));
    loadStart(mk(0, 0, 0, 1, 35));
    pushWords(41);
    check("R11 table default", curAddr, mk(0, 0, 0, 2, 0));
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tResetState();
    tBoundary();
    tMinorWrap();
    tTable();
    tRowHalf();
    tEnd();
    tLoad();
    tResetMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule